// File: doc/BRIEF.md
# I2C Target Interface with General-Call Reset

This block is the two-wire serial target port of a small peripheral. It samples the clock line (SCL) and the data line (SDA) with a fast system clock. From those samples it detects start, repeated start and stop conditions. It matches a 7-bit target address whose lowest bit comes from an external strap pin, so two identical peripherals can share one bus. It acknowledges the bytes it accepts, turns a four-byte write transaction into a single register-write strobe, and shifts 16-bit register contents out MSB first when the controller reads.

The block also watches for a general call. The reserved all-zero address, followed by the byte 0x06, produces a one-cycle software-reset pulse. That pulse fires when the acknowledge clock of the second byte falls, not at the stop that follows.

SDA is driven only through an open-drain enable: while `sda_oe_o` is high, the pad pulls the line low. The block never holds SCL low, so it cannot stretch the clock. The register file sits outside the block. Reads use a combinational data port that is addressed by the current register pointer.

Top module: `i2c_gc_target`

## Requirements
- R1: `mode_sel_i` is captured during reset and held. When it was low, the block never asserts `sda_oe_o`, never acknowledges and issues no strobe, read request or reset pulse.
- R2: The target address is {ADDR_HI, `addr_pin_i`}, which is 0x48 or 0x49 with the default ADDR_HI = 6'b100100. An address byte whose upper seven bits differ from it, and that is not a general call, is not acknowledged.
- R3: Only 7-bit addressing is served. A ten-bit prefix such as 0xF0 is not acknowledged. The general-call address with the read bit set (byte 0x01) is not acknowledged either.
- R4: An acknowledge holds `sda_oe_o` high from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock. `sda_oe_o` never changes while the synchronised SCL stays high. A not-acknowledge leaves SDA released.
- R5: A write transaction has four bytes: the address with the R/W bit at 0, a command byte, a high data byte and a low data byte. The low 4 bits of the command byte select the register. After the fourth acknowledge, `wr_stb_o` pulses for one cycle, with `reg_addr_o` set to the selected register and `wr_data_o` set to {high byte, low byte}.
- R6: Bytes after the fourth byte of a write are not acknowledged and cause no further strobe.
- R7: A read sets the register pointer with an address byte and a command byte. It then sends a repeated start with the R/W bit at 1. The block pulses `rd_req_o` and returns `rd_data_i` as two bytes, MSB first. A controller not-acknowledge ends the transfer and SDA stays released from then on.
- R8: A repeated start abandons the transfer in progress. A partial write gives no strobe, and address matching begins again.
- R9: The address byte 0x00 followed by the byte 0x06 is acknowledged. `gc_reset_o` then pulses for one cycle, while SCL is low, just after the second acknowledge clock falls and before any stop.
- R10: After a general-call address, any second byte other than 0x06 is not acknowledged and gives no reset pulse.
- R11: A stop condition returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel_i | input | 1 | Serial-mode enable, captured during reset |
| addr_pin_i | input | 1 | Strap pin giving the lowest address bit |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low when high (open drain) |
| reg_addr_o | output | 4 | Register pointer from the command byte |
| wr_stb_o | output | 1 | One-cycle register-write strobe |
| wr_data_o | output | 16 | Write data, high byte first on the bus |
| rd_req_o | output | 1 | One-cycle pulse when read data is captured |
| rd_data_i | input | 16 | Register contents at `reg_addr_o` |
| gc_reset_o | output | 1 | One-cycle general-call software reset |

## Verification
A wrong phase or bit count inside the block shows up on the bus within one SCL period. The acknowledge moves to the wrong ninth clock, or the target pulls SDA low where the controller expects the line released. The bench flags this on the very clock where it happens. A corrupted byte index or pointer shows up at the end of the transaction, as a missing or extra write strobe, a wrong strobe payload, a read returning the wrong value, or a reset pulse that comes late, at the stop, or not at all.

// File: rtl/i2c_gc_pkg.sv
// Shared types and constants for the serial target port.
// Assumes the bus carries bytes MSB first and that data is 16 bits wide.
package i2c_gc_pkg;

    localparam int BYTE_W      = 8;
    localparam int DATA_W      = 16;
    localparam int BITCNT_W    = 4;
    localparam logic [7:0] GC_ADDR_BYTE  = 8'h00;
    localparam logic [7:0] GC_RESET_BYTE = 8'h06;

    // Protocol phase of the target state machine
    typedef enum logic [2:0] {
        PH_IDLE,   // bus idle or block disabled
        PH_RX,     // shifting in a byte
        PH_ACK,    // driving acknowledge on the ninth clock
        PH_TX,     // shifting out a byte
        PH_MACK,   // reading the controller's acknowledge
        PH_WAIT    // ignoring the bus until start or stop
    } phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the system clock domain and detects edges and
// bus conditions on the synchronised copies.
// Assumes both lines idle high; the reset value matches that, so leaving
// reset produces no spurious start or stop.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic scl_prev;
    logic sda_prev;

    // Shift both lines through the synchroniser plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    // Decode edges and conditions from the current and previous samples
    always_comb begin
        scl_o      = scl_pipe[STAGES-1];
        sda_o      = sda_pipe[STAGES-1];
        scl_prev   = scl_pipe[STAGES];
        sda_prev   = sda_pipe[STAGES];
        scl_rise_o = scl_o & ~scl_prev;
        scl_fall_o = ~scl_o & scl_prev;
        start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
        stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
    end

endmodule

// File: rtl/i2c_target_fsm.sv
// Byte-level protocol engine of the target. It receives bytes, decides
// whether to acknowledge, collects write data, serves reads from a
// combinational data port and decodes the general-call reset.
// Assumes SDA changes only while SCL is low, except at start and stop,
// and that SCL stays low for several system clocks.
module i2c_target_fsm
    import i2c_gc_pkg::*;
#(
    parameter int         REG_AW  = 4,
    parameter logic [5:0] ADDR_HI = 6'b100100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                addr_pin_i,
    input  logic                sda_i,
    input  logic                scl_rise_i,
    input  logic                scl_fall_i,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic [DATA_W-1:0]   rd_data_i,
    output logic                sda_oe_o,
    output logic [REG_AW-1:0]   reg_addr_o,
    output logic                wr_stb_o,
    output logic [DATA_W-1:0]   wr_data_o,
    output logic                rd_req_o,
    output logic                gc_reset_o
);

    localparam logic [BITCNT_W-1:0] LAST_RX_CNT = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] LAST_TX_CNT = BITCNT_W'(BYTE_W - 1);

    phase_t              phase;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [1:0]          byte_idx;
    logic [BYTE_W-1:0]   rx_sh;
    logic [DATA_W-1:0]   tx_sh;
    logic [BYTE_W-1:0]   hi_byte;
    logic                is_gc;
    logic                is_rd;
    logic                tx_second;
    logic                ctrl_ack;
    logic                take_byte;
    logic [6:0]          own_addr;

    // Decide whether the byte just received deserves an acknowledge
    always_comb begin
        own_addr = {ADDR_HI, addr_pin_i};
        unique case (byte_idx)
            2'd0:    take_byte = (rx_sh[7:1] == own_addr) || (rx_sh == GC_ADDR_BYTE);
            2'd1:    take_byte = is_gc ? (rx_sh == GC_RESET_BYTE) : 1'b1;
            default: take_byte = ~is_gc;
        endcase
    end

    // Protocol sequencing, byte capture and output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            byte_idx   <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            hi_byte    <= '0;
            is_gc      <= 1'b0;
            is_rd      <= 1'b0;
            tx_second  <= 1'b0;
            ctrl_ack   <= 1'b0;
            sda_oe_o   <= 1'b0;
            reg_addr_o <= '0;
            wr_data_o  <= '0;
            wr_stb_o   <= 1'b0;
            rd_req_o   <= 1'b0;
            gc_reset_o <= 1'b0;
        end else begin
            wr_stb_o   <= 1'b0;
            rd_req_o   <= 1'b0;
            gc_reset_o <= 1'b0;
            if (!en_i || stop_i) begin
                phase    <= PH_IDLE;
                sda_oe_o <= 1'b0;
            end else if (start_i) begin
                phase    <= PH_RX;
                bit_cnt  <= '0;
                byte_idx <= '0;
                is_gc    <= 1'b0;
                is_rd    <= 1'b0;
                sda_oe_o <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RX: begin
                        if (scl_rise_i && bit_cnt != LAST_RX_CNT) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_i};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall_i && bit_cnt == LAST_RX_CNT) begin
                            if (take_byte) begin
                                phase    <= PH_ACK;
                                sda_oe_o <= 1'b1;
                                unique case (byte_idx)
                                    2'd0: begin
                                        is_rd <= rx_sh[0];
                                        is_gc <= (rx_sh == GC_ADDR_BYTE);
                                    end
                                    2'd1: if (!is_gc) reg_addr_o <= rx_sh[REG_AW-1:0];
                                    2'd2: hi_byte <= rx_sh;
                                    default: wr_data_o <= {hi_byte, rx_sh};
                                endcase
                            end else begin
                                phase <= PH_WAIT;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall_i) begin
                            bit_cnt <= '0;
                            if (is_rd) begin
                                phase     <= PH_TX;
                                tx_sh     <= rd_data_i;
                                sda_oe_o  <= ~rd_data_i[DATA_W-1];
                                rd_req_o  <= 1'b1;
                                tx_second <= 1'b0;
                            end else if (is_gc && byte_idx == 2'd1) begin
                                sda_oe_o   <= 1'b0;
                                gc_reset_o <= 1'b1;
                                phase      <= PH_WAIT;
                            end else if (byte_idx == 2'd3) begin
                                sda_oe_o <= 1'b0;
                                wr_stb_o <= 1'b1;
                                phase    <= PH_WAIT;
                            end else begin
                                sda_oe_o <= 1'b0;
                                byte_idx <= byte_idx + 1'b1;
                                phase    <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall_i) begin
                            if (bit_cnt == LAST_TX_CNT) begin
                                phase    <= PH_MACK;
                                sda_oe_o <= 1'b0;
                            end else begin
                                tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
                                sda_oe_o <= ~tx_sh[DATA_W-2];
                                bit_cnt  <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    PH_MACK: begin
                        if (scl_rise_i) begin
                            ctrl_ack <= ~sda_i;
                        end else if (scl_fall_i) begin
                            if (ctrl_ack && !tx_second) begin
                                phase     <= PH_TX;
                                tx_second <= 1'b1;
                                bit_cnt   <= '0;
                                tx_sh     <= {tx_sh[DATA_W-2:0], 1'b0};
                                sda_oe_o  <= ~tx_sh[DATA_W-2];
                            end else begin
                                phase <= PH_WAIT;
                            end
                        end
                    end
                    default: sda_oe_o <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_gc_target.sv
// Top of the serial target port. It captures the mode enable during reset,
// synchronises the bus lines and runs the protocol engine.
// Assumes an open-drain pad outside: sda_oe_o high pulls SDA low, and
// rd_data_i follows reg_addr_o combinationally.
module i2c_gc_target
    import i2c_gc_pkg::*;
#(
    parameter int         REG_AW      = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = 6'b100100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel_i,
    input  logic              addr_pin_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [REG_AW-1:0] reg_addr_o,
    output logic              wr_stb_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_req_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              gc_reset_o
);

    logic en_q;
    logic scl_s;
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    // Hold the mode pin value seen while reset is asserted
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= mode_sel_i;
    end

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_target_fsm #(
        .REG_AW  (REG_AW),
        .ADDR_HI (ADDR_HI)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_q),
        .addr_pin_i (addr_pin_i),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .rd_data_i  (rd_data_i),
        .sda_oe_o   (sda_oe_o),
        .reg_addr_o (reg_addr_o),
        .wr_stb_o   (wr_stb_o),
        .wr_data_o  (wr_data_o),
        .rd_req_o   (rd_req_o),
        .gc_reset_o (gc_reset_o)
    );

endmodule

// File: rtl/i2c_gc_target_chk.sv
// Protocol properties of the serial target, bound into the top module.
// Assumes the bound signals are the top's mode latch, synchronised SCL
// and stop detection.
module i2c_gc_target_chk (
    input logic clk,
    input logic rst_n,
    input logic en_q,
    input logic scl_s,
    input logic stop_det,
    input logic sda_oe_o,
    input logic wr_stb_o,
    input logic rd_req_o,
    input logic gc_reset_o
);

    // A disabled block never pulls the data line
    assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !sda_oe_o);

    // The data-line drive holds steady while SCL stays high
    assert_drive_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

    // Write strobe lasts a single cycle
    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // Read request lasts a single cycle
    assert_rd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // Reset pulse lasts a single cycle
    assert_gc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset_o |=> !gc_reset_o);

    // Reset pulse occurs in the SCL low phase after the acknowledge
    assert_gc_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset_o |-> !scl_s);

    // At most one transaction event per cycle
    assert_one_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb_o, rd_req_o, gc_reset_o}));

    // The line is released right after a stop
    assert_release_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

endmodule

bind i2c_gc_target i2c_gc_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .scl_s      (scl_s),
    .stop_det   (stop_det),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb_o),
    .rd_req_o   (rd_req_o),
    .gc_reset_o (gc_reset_o)
);

// File: tb/i2c_gc_target_bench.sv
// Bench for the serial target: a behavioural bus controller, a register
// array and an expectation model that is compared on every clock.
module i2c_gc_target_bench;

    localparam int Q = 12;   // system clocks per quarter SCL period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b1;
    logic        addr_pin = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [3:0]  reg_addr;
    logic        wr_stb;
    logic [15:0] wr_data;
    logic        rd_req;
    logic [15:0] rd_data;
    logic        gc_rst;

    logic [15:0] regs  [16];
    logic [15:0] model [16];
    logic [19:0] exp_q [$];
    int n_chk = 0;
    int n_err = 0;
    int gc_cnt = 0;
    int rd_cnt = 0;
    bit win = 1'b0;
    bit any_drive = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = regs[reg_addr];

    i2c_gc_target u_i2c_gc_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel_i (mode_sel),
        .addr_pin_i (addr_pin),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .reg_addr_o (reg_addr),
        .wr_stb_o   (wr_stb),
        .wr_data_o  (wr_data),
        .rd_req_o   (rd_req),
        .rd_data_i  (rd_data),
        .gc_reset_o (gc_rst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of drive and events against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe) begin
                any_drive = 1'b1;
                check(win, "R4 drive outside acknowledge/read slot", 1, 0);
            end
            if (wr_stb) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R6/R8 unexpected write strobe", {reg_addr, wr_data}, 0);
                end else begin
                    logic [19:0] e;
                    e = exp_q.pop_front();
                    check({reg_addr, wr_data} == e, "R5 strobe payload", {reg_addr, wr_data}, e);
                end
                regs[reg_addr] = wr_data;
            end
            if (gc_rst) gc_cnt++;
            if (rd_req) rd_cnt++;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic wb(input logic [7:0] b, input bit keep, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0;
            if (i == 0) win = 1'b1;
            wq(Q);
        end
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        acked = !sda_line;
        wq(Q); scl_m = 1'b0; wq(Q);
        if (!keep) win = 1'b0;
    endtask

    task automatic rb(input bit mack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
            v[i] = sda_line;
            wq(Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = !mack; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [3:0] r, input logic [15:0] d,
                            input bit expect_ack);
        bit ak;
        bus_start;
        wb({a, 1'b0}, 1'b0, ak);
        check(ak == expect_ack, "R2 address acknowledge", ak, expect_ack);
        if (ak) begin
            exp_q.push_back({r, d});
            model[r] = d;
            wb({4'h0, r}, 1'b0, ak);  check(ak, "R5 command acknowledge", ak, 1);
            wb(d[15:8], 1'b0, ak);    check(ak, "R5 high byte acknowledge", ak, 1);
            wb(d[7:0], 1'b0, ak);     check(ak, "R5 low byte acknowledge", ak, 1);
        end
        bus_stop;
        check(exp_q.size() == 0, "R5 strobe after fourth acknowledge", exp_q.size(), 0);
    endtask

    task automatic do_read(input logic [6:0] a, input logic [3:0] r);
        bit ak;
        logic [7:0] hi, lo;
        int rc;
        bus_start;
        wb({a, 1'b0}, 1'b0, ak);
        wb({4'h0, r}, 1'b0, ak);
        rc = rd_cnt;
        bus_start;
        wb({a, 1'b1}, 1'b1, ak);
        check(ak, "R7 read address acknowledge", ak, 1);
        rb(1'b1, hi);
        rb(1'b0, lo);
        win = 1'b0;
        bus_stop;
        check({hi, lo} == model[r], "R7 read data MSB first", {hi, lo}, model[r]);
        check(rd_cnt == rc + 1, "R7 read request pulse", rd_cnt, rc + 1);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        bit ak;
        logic [7:0] v;
        int g;
        for (int i = 0; i < 16; i++) begin
            regs[i]  = 16'h0000;
            model[i] = 16'h0000;
        end
        wq(6);
        rst_n = 1'b1;
        wq(4);
        // Reset state
        check(!sda_oe && !wr_stb && !rd_req && !gc_rst, "R1 reset outputs idle",
              {sda_oe, wr_stb, rd_req, gc_rst}, 0);

        // Addressed writes and reads, address pin low (0x48)
        do_write(7'h48, 4'h3, 16'hA55A, 1'b1);
        do_write(7'h48, 4'hC, 16'h0180, 1'b1);
        do_read(7'h48, 4'h3);
        do_read(7'h48, 4'hC);
        // Wrong address and pin-dependent matching
        do_write(7'h49, 4'h1, 16'h1234, 1'b0);
        addr_pin = 1'b1;
        do_write(7'h49, 4'h1, 16'hBEEF, 1'b1);
        do_write(7'h48, 4'h2, 16'h1111, 1'b0);
        do_read(7'h49, 4'h1);
        addr_pin = 1'b0;

        // Ten-bit prefix and general call with read bit
        bus_start; wb(8'hF0, 1'b0, ak); bus_stop;
        check(!ak, "R3 ten-bit prefix not acknowledged", ak, 0);
        bus_start; wb(8'h01, 1'b0, ak); bus_stop;
        check(!ak, "R3 general call read not acknowledged", ak, 0);

        // Fifth byte refused, only one strobe
        bus_start;
        exp_q.push_back({4'h5, 16'h7E81});
        model[5] = 16'h7E81;
        wb(8'h90, 1'b0, ak); wb(8'h05, 1'b0, ak); wb(8'h7E, 1'b0, ak); wb(8'h81, 1'b0, ak);
        wb(8'h33, 1'b0, ak);
        check(!ak, "R6 fifth byte not acknowledged", ak, 0);
        bus_stop;
        check(exp_q.size() == 0, "R6 single strobe", exp_q.size(), 0);

        // Repeated start aborts a partial write
        bus_start;
        wb(8'h90, 1'b0, ak); wb(8'h07, 1'b0, ak); wb(8'hDE, 1'b0, ak);
        bus_start;
        wb(8'h90, 1'b0, ak);
        check(ak, "R8 address match after repeated start", ak, 1);
        exp_q.push_back({4'h6, 16'h4242});
        model[6] = 16'h4242;
        wb(8'h06, 1'b0, ak); wb(8'h42, 1'b0, ak); wb(8'h42, 1'b0, ak);
        bus_stop;
        check(exp_q.size() == 0, "R8 only completed write strobes", exp_q.size(), 0);
        do_read(7'h48, 4'h7);

        // Controller NACK after first byte releases the line
        bus_start;
        wb(8'h90, 1'b0, ak); wb(8'h03, 1'b0, ak);
        bus_start;
        wb(8'h91, 1'b1, ak);
        rb(1'b0, v);
        check(v == model[3][15:8], "R7 first byte before NACK", v, model[3][15:8]);
        win = 1'b0;
        rb(1'b0, v);
        check(v == 8'hFF, "R7 line released after NACK", v, 8'hFF);
        bus_stop;
        check(!sda_oe, "R11 released after stop", sda_oe, 0);

        // General-call reset fires before the stop
        g = gc_cnt;
        bus_start;
        wb(8'h00, 1'b0, ak); check(ak, "R9 general call acknowledged", ak, 1);
        wb(8'h06, 1'b0, ak); check(ak, "R9 reset byte acknowledged", ak, 1);
        check(gc_cnt == g + 1, "R9 reset pulse before stop", gc_cnt, g + 1);
        bus_stop;
        check(gc_cnt == g + 1, "R9 exactly one reset pulse", gc_cnt, g + 1);

        // General call with another byte
        bus_start;
        wb(8'h00, 1'b0, ak);
        wb(8'h07, 1'b0, ak); check(!ak, "R10 other byte not acknowledged", ak, 0);
        bus_stop;
        check(gc_cnt == g + 1, "R10 no reset pulse", gc_cnt, g + 1);

        // Disabled mode: reset with mode select low
        rst_n = 1'b0; mode_sel = 1'b0; wq(6); rst_n = 1'b1; mode_sel = 1'b1; wq(4);
        any_drive = 1'b0;
        bus_start; wb(8'h90, 1'b0, ak); bus_stop;
        check(!ak, "R1 disabled block ignores its address", ak, 0);
        bus_start; wb(8'h00, 1'b0, ak); wb(8'h06, 1'b0, ak); bus_stop;
        check(gc_cnt == g + 1, "R1 disabled block gives no reset", gc_cnt, g + 1);
        check(!any_drive, "R1 disabled block never drives SDA", any_drive, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule